// File: doc/BRIEF.md
# Two-Line Collapsing Fetch Packer

This block builds one dense fetch packet from two instruction-cache lines that were read in the same cycle, one from each cache bank. Branch prediction, done elsewhere, decides which of the two lines comes first in predicted program order. It also decides which instruction slots of each line lie on the predicted path. A slot is dropped if it precedes the line's entry point or follows a predicted-taken branch inside that line.

The block takes the two bank lines, one select that says whether the bank-1 line comes first, and one slot-valid mask per bank. An interchange stage puts the lines, together with their masks, into predicted order. A compaction stage then shifts every surviving instruction down into consecutive output slots. The instructions between a taken branch and its target are removed, so the packet holds only the instructions on the predicted path. The packed instructions, their count and a valid flag are registered and appear one cycle after the request.

Top module: `cbf_fetch_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs after that edge are `pkt_vld`=0, `pkt_cnt`=0 and `pkt_insn` all zeros.
- R2: `pkt_vld` after a rising edge equals the value `fetch_vld` had at that edge, so a packet appears one cycle after its request.
- R3: When `bank1_first`=0, the bank-0 line is placed first in predicted order. When `bank1_first`=1, the bank-1 line is placed first. Each mask travels with its own line.
- R4: Slot k of a line is bits [k*INSN_W +: INSN_W] of that line, and mask bit k marks that slot as valid. The surviving instructions fill output slots 0, 1, 2 and so on, in order: first line, then second line, ascending slot index within each line. Output slot j is bits [j*INSN_W +: INSN_W] of `pkt_insn`.
- R5: `pkt_cnt` equals the total number of set bits in the two masks. It ranges from 0 to 2*LINE_SLOTS.
- R6: Output slots at index `pkt_cnt` and above are zero.
- R7: With both masks zero, the packet is all zeros with count 0, and `pkt_vld` is still 1.
- R8: With both masks full, the packet is the first line followed by the second line, unchanged, with count 2*LINE_SLOTS.
- R9: A cycle with `fetch_vld`=0 leaves `pkt_insn` and `pkt_cnt` unchanged, whatever the line, mask and select inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_vld | input | 1 | Request: lines, masks and select are meaningful |
| bank0_line | input | LINE_SLOTS*INSN_W | Line read from cache bank 0 |
| bank1_line | input | LINE_SLOTS*INSN_W | Line read from cache bank 1 |
| bank0_mask | input | LINE_SLOTS | Slot-valid mask for the bank-0 line |
| bank1_mask | input | LINE_SLOTS | Slot-valid mask for the bank-1 line |
| bank1_first | input | 1 | 1: bank-1 line is first in predicted order |
| pkt_vld | output | 1 | Packet valid |
| pkt_insn | output | 2*LINE_SLOTS*INSN_W | Packed instructions, slot 0 in the low bits |
| pkt_cnt | output | $clog2(2*LINE_SLOTS+1) | Number of packed instructions |

## Verification
The bank swap and the compaction act on the same request. A swap error could hide behind a mask pattern that happens to be symmetric. To rule this out, the vector table sets `bank1_first` together with masks that differ between the banks and leave gaps in both lines. Each line carries distinct instruction tags, so each expected packet is a specific tag sequence, and a misrouted line or a misplaced survivor changes that sequence. The packed order, the count and the zeroed tail are checked together on the cycle after each request.

// File: rtl/cbf_pkg.sv
// Package: shared defaults for the collapsing fetch packer.
// Assumes: every instance takes its geometry from these values unless overridden.
package cbf_pkg;
    localparam int unsigned CBF_INSN_W     = 32;
    localparam int unsigned CBF_LINE_SLOTS = 4;
endpackage

// File: rtl/cbf_interchange.sv
// Module: cbf_interchange
// Puts the two bank lines, with their slot masks, into predicted program order.
// Assumes: sel_b1_first is valid in the same cycle as the lines; purely combinational.
module cbf_interchange #(
    parameter int unsigned INSN_W     = cbf_pkg::CBF_INSN_W,
    parameter int unsigned LINE_SLOTS = cbf_pkg::CBF_LINE_SLOTS,
    localparam int unsigned LINE_W    = INSN_W * LINE_SLOTS
) (
    input  logic [LINE_W-1:0]     b0_line,
    input  logic [LINE_W-1:0]     b1_line,
    input  logic [LINE_SLOTS-1:0] b0_mask,
    input  logic [LINE_SLOTS-1:0] b1_mask,
    input  logic                  sel_b1_first,
    output logic [LINE_W-1:0]     lead_line,
    output logic [LINE_W-1:0]     trail_line,
    output logic [LINE_SLOTS-1:0] lead_mask,
    output logic [LINE_SLOTS-1:0] trail_mask
);

    // Swap lines and masks as a pair when bank 1 leads.
    always_comb begin
        if (sel_b1_first) begin
            lead_line  = b1_line;
            lead_mask  = b1_mask;
            trail_line = b0_line;
            trail_mask = b0_mask;
        end else begin
            lead_line  = b0_line;
            lead_mask  = b0_mask;
            trail_line = b1_line;
            trail_mask = b1_mask;
        end
    end

    // The switch must neither create nor lose valid slots (R3).
    always_comb begin
        p_mask_kept_r3: assert ($countones({lead_mask, trail_mask}) ==
                                $countones({b0_mask, b1_mask}));
    end

endmodule

// File: rtl/cbf_collapse.sv
// Module: cbf_collapse
// Packs the valid slots of an ordered slot array into consecutive low output slots.
// Assumes: slot 0 of the input is earliest in program order; purely combinational.
module cbf_collapse #(
    parameter int unsigned INSN_W = cbf_pkg::CBF_INSN_W,
    parameter int unsigned SLOTS  = 2 * cbf_pkg::CBF_LINE_SLOTS,
    localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS*INSN_W-1:0] slot_in,
    input  logic [SLOTS-1:0]        slot_ok,
    output logic [SLOTS*INSN_W-1:0] slot_out,
    output logic [CNT_W-1:0]        slot_cnt
);

    logic [CNT_W-1:0] dest [SLOTS];

    // Output position of each input slot: number of valid slots below it.
    always_comb begin
        logic [CNT_W-1:0] run;
        run = '0;
        for (int i = 0; i < SLOTS; i++) begin
            dest[i] = run;
            run     = run + CNT_W'(slot_ok[i]);
        end
        slot_cnt = run;
    end

    // Each output slot selects the one valid input whose position matches it.
    for (genvar j = 0; j < SLOTS; j++) begin : g_out
        always_comb begin
            slot_out[j*INSN_W +: INSN_W] = '0;
            for (int i = j; i < SLOTS; i++) begin
                if (slot_ok[i] && dest[i] == CNT_W'(j))
                    slot_out[j*INSN_W +: INSN_W] = slot_in[i*INSN_W +: INSN_W];
            end
        end
    end

endmodule

// File: rtl/cbf_fetch_unit.sv
// Module: cbf_fetch_unit (top)
// Orders two same-cycle bank lines, collapses off-path slots, and registers the packet.
// Assumes: masks already clear slots before the entry point and after a taken branch.
module cbf_fetch_unit #(
    parameter int unsigned INSN_W     = cbf_pkg::CBF_INSN_W,
    parameter int unsigned LINE_SLOTS = cbf_pkg::CBF_LINE_SLOTS,
    localparam int unsigned LINE_W    = INSN_W * LINE_SLOTS,
    localparam int unsigned PKT_SLOTS = 2 * LINE_SLOTS,
    localparam int unsigned CNT_W     = $clog2(PKT_SLOTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fetch_vld,
    input  logic [LINE_W-1:0]           bank0_line,
    input  logic [LINE_W-1:0]           bank1_line,
    input  logic [LINE_SLOTS-1:0]       bank0_mask,
    input  logic [LINE_SLOTS-1:0]       bank1_mask,
    input  logic                        bank1_first,
    output logic                        pkt_vld,
    output logic [PKT_SLOTS*INSN_W-1:0] pkt_insn,
    output logic [CNT_W-1:0]            pkt_cnt
);

    logic [LINE_W-1:0]           lead_line, trail_line;
    logic [LINE_SLOTS-1:0]       lead_mask, trail_mask;
    logic [PKT_SLOTS*INSN_W-1:0] packed_d;
    logic [CNT_W-1:0]            cnt_d;

    cbf_interchange #(.INSN_W(INSN_W), .LINE_SLOTS(LINE_SLOTS)) u_swap (
        .b0_line      (bank0_line),
        .b1_line      (bank1_line),
        .b0_mask      (bank0_mask),
        .b1_mask      (bank1_mask),
        .sel_b1_first (bank1_first),
        .lead_line    (lead_line),
        .trail_line   (trail_line),
        .lead_mask    (lead_mask),
        .trail_mask   (trail_mask)
    );

    cbf_collapse #(.INSN_W(INSN_W), .SLOTS(PKT_SLOTS)) u_pack (
        .slot_in  ({trail_line, lead_line}),
        .slot_ok  ({trail_mask, lead_mask}),
        .slot_out (packed_d),
        .slot_cnt (cnt_d)
    );

    // Output register: valid follows the request, data loads only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_vld  <= 1'b0;
            pkt_insn <= '0;
            pkt_cnt  <= '0;
        end else begin
            pkt_vld <= fetch_vld;
            if (fetch_vld) begin
                pkt_insn <= packed_d;
                pkt_cnt  <= cnt_d;
            end
        end
    end

    // R1: reset clears the packet outputs.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!pkt_vld && pkt_cnt == '0 && pkt_insn == '0));

    // R2: one-cycle request-to-packet latency.
    p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld |=> pkt_vld);

    // R5: count matches the number of valid mask bits of the request.
    p_cnt_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld |=> (pkt_cnt == CNT_W'($countones($past({bank0_mask, bank1_mask})))));

    // R9: idle cycles keep the packet contents.
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |=> ($stable(pkt_insn) && $stable(pkt_cnt)));

    // R6: slots at or above the count stay zero.
    for (genvar j = 0; j < PKT_SLOTS; j++) begin : g_tail_chk
        p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (pkt_cnt <= CNT_W'(j)) |-> (pkt_insn[j*INSN_W +: INSN_W] == '0));
    end

endmodule

// File: tb/cbf_fetch_unit_bench.sv
// Bench for cbf_fetch_unit: a vector table, then directed reset and idle tests.
module cbf_fetch_unit_bench;

    localparam int W = 32;
    localparam int S = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fetch_vld = 1'b0;
    logic [S*W-1:0]  bank0_line, bank1_line;
    logic [S-1:0]    bank0_mask = '0, bank1_mask = '0;
    logic            bank1_first = 1'b0;
    logic            pkt_vld;
    logic [2*S*W-1:0] pkt_insn;
    logic [3:0]      pkt_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    cbf_fetch_unit u_cbf_fetch_unit (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld),
        .bank0_line(bank0_line), .bank1_line(bank1_line),
        .bank0_mask(bank0_mask), .bank1_mask(bank1_mask),
        .bank1_first(bank1_first),
        .pkt_vld(pkt_vld), .pkt_insn(pkt_insn), .pkt_cnt(pkt_cnt)
    );

    // Vector: {bank1_first, bank0_mask, bank1_mask, expected count, expected tags}.
    // Expected tags: byte j is the tag in output slot j, 0 for an empty slot.
    localparam logic [76:0] VEC [10] = '{
        {1'b0, 4'hF, 4'hF, 4'd8, 64'hB3B2B1B0_A3A2A1A0},  // R8 full, bank 0 first
        {1'b1, 4'hF, 4'hF, 4'd8, 64'hA3A2A1A0_B3B2B1B0},  // R8 R3 full, swapped
        {1'b0, 4'h7, 4'h5, 4'd5, 64'h000000B2_B0A2A1A0},  // R4 gap in second line
        {1'b1, 4'hC, 4'h3, 4'd4, 64'h00000000_A3A2B1B0},  // R3 swapped, partial both
        {1'b0, 4'h0, 4'h0, 4'd0, 64'h00000000_00000000},  // R7 empty
        {1'b0, 4'h8, 4'h1, 4'd2, 64'h00000000_0000B0A3},  // R4 late entry, early taken
        {1'b1, 4'h0, 4'hE, 4'd3, 64'h00000000_00B3B2B1},  // R3 lead only, entry at 1
        {1'b0, 4'h6, 4'h0, 4'd2, 64'h00000000_0000A2A1},  // R6 one line, interior
        {1'b1, 4'hF, 4'h0, 4'd4, 64'h00000000_A3A2A1A0},  // R3 trailing line only
        {1'b1, 4'h1, 4'h8, 4'd2, 64'h00000000_0000A0B3}   // R4 last of lead, first of trail
    };

    function automatic logic [2*S*W-1:0] tags_to_pkt(input logic [63:0] tags);
        logic [2*S*W-1:0] p = '0;
        for (int j = 0; j < 2*S; j++) p[j*W +: W] = {24'h0, tags[j*8 +: 8]};
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive lines: bank0 slot k holds tag A0+k, bank1 slot k holds tag B0+k.
    initial begin
        for (int k = 0; k < S; k++) begin
            bank0_line[k*W +: W] = 32'hA0 + k;
            bank1_line[k*W +: W] = 32'hB0 + k;
        end
    end

    initial begin
        logic [2*S*W-1:0] last_pkt;
        logic [3:0]       last_cnt;
        // Reset state (R1).
        repeat (3) @(negedge clk);
        check(pkt_vld == 1'b0, "R1 vld", 128'(pkt_vld), 0);
        check(pkt_cnt == 4'd0, "R1 cnt", 128'(pkt_cnt), 0);
        check(pkt_insn == '0, "R1 pkt", pkt_insn[127:0], 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table (R2 R3 R4 R5 R6 R7 R8).
        for (int v = 0; v < 10; v++) begin
            bank1_first = VEC[v][76];
            bank0_mask  = VEC[v][75:72];
            bank1_mask  = VEC[v][71:68];
            fetch_vld   = 1'b1;
            @(negedge clk);
            check(pkt_vld == 1'b1, "R2 vld", 128'(pkt_vld), 1);
            check(pkt_cnt == VEC[v][67:64], "R5 cnt", 128'(pkt_cnt), 128'(VEC[v][67:64]));
            check(pkt_insn == tags_to_pkt(VEC[v][63:0]), "R4 R6 pkt",
                  pkt_insn[127:0], tags_to_pkt(VEC[v][63:0]) & 128'(256'h0) |
                  128'(VEC[v][63:0]));
        end

        // Idle cycle with changed inputs leaves the packet alone (R9, R2).
        last_pkt    = pkt_insn;
        last_cnt    = pkt_cnt;
        fetch_vld   = 1'b0;
        bank1_first = 1'b0;
        bank0_mask  = 4'hF;
        bank1_mask  = 4'hF;
        @(negedge clk);
        check(pkt_vld == 1'b0, "R2 idle vld", 128'(pkt_vld), 0);
        check(pkt_cnt == last_cnt, "R9 cnt", 128'(pkt_cnt), 128'(last_cnt));
        check(pkt_insn == last_pkt, "R9 pkt", pkt_insn[127:0], last_pkt[127:0]);
        @(negedge clk);
        check(pkt_insn == last_pkt, "R9 pkt 2nd", pkt_insn[127:0], last_pkt[127:0]);

        // Back-to-back requests after idle: second overwrites first (R2 R5).
        fetch_vld = 1'b1;
        @(negedge clk);
        check(pkt_cnt == 4'd8, "R5 full after idle", 128'(pkt_cnt), 8);
        bank0_mask = 4'h2;
        bank1_mask = 4'h4;
        bank1_first = 1'b1;
        @(negedge clk);
        check(pkt_cnt == 4'd2, "R5 b2b cnt", 128'(pkt_cnt), 2);
        check(pkt_insn == tags_to_pkt(64'h000000000000A1B2), "R3 b2b pkt",
              pkt_insn[127:0], 128'h000000A1_000000B2);

        // Reset in mid-run clears everything (R1).
        rst_n = 1'b0;
        @(negedge clk);
        check(pkt_vld == 1'b0 && pkt_cnt == 4'd0 && pkt_insn == '0, "R1 mid-run",
              pkt_insn[127:0], 0);
        rst_n     = 1'b1;
        fetch_vld = 1'b0;
        @(negedge clk);
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!done && cyc < 2000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule